// File: doc/BRIEF.md
# Pin Interrupt Detector with Sampled Debounce

This block watches a bank of already-synchronized pin inputs and turns chosen transitions or levels on them into per-pin interrupt status bits. Software selects, pin by pin, whether a pin reacts to edges or to levels. It also selects which polarity arms the pin, and whether the pin passes through a debounce filter before detection. A pending bit is cleared by writing a one to it. The block drives one interrupt request, which is the OR of all pending bits.

The debounce filter samples its pins only when a shared divider fires. The divider counts 2^N ticks of one of two clock-enable inputs: a fast system tick or a slow low-power tick. For example, a 32 kHz slow tick with N = 2 samples every 125 us. A filtered pin takes a new level only when two sampling points in a row see that level. A global keep-alive switch decides how a pin's previous-level register behaves. When the switch is set, the register tracks the pin at all times. When it is clear, the register tracks only while the pin has an enable set. With the switch clear, a pin that changed while it was unarmed reports the change as soon as it is armed.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset every status bit is 0 and the interrupt request is low.
- R2: Address 0 holds the enables. Bit NPIN+i arms pin i for a rising edge or a high level. Bit i arms it for a falling edge or a low level. In edge mode, a qualifying change at the pin sets status bit i on the first clock edge at which the new value is present. With both bits set, either edge sets it.
- R3: Address 1 holds one type bit per pin: 0 selects edge mode and 1 selects level mode. In level mode, status bit i is set on every clock while the armed level is present. It is set again even after it has been cleared.
- R4: Bits [3:0] at address 3 hold N. The debounce sampling point recurs every 2^N selected ticks. A low pulse of 10 cycles is ignored when N = 4, and a hold of 40 cycles is accepted.
- R5: Bit 4 at address 3 selects the tick that drives the divider: 0 is the system tick and 1 is the slow tick. Any write to address 3 restarts the divider.
- R6: Address 2 enables debounce, one bit per pin. A filtered pin takes a new level only when two consecutive sampling points agree on it. A one-cycle glitch is ignored, and a level held for 12 cycles at N = 2 is accepted.
- R7: Bit 5 at address 3 is the keep-alive switch. When it is 1, every pin's previous level tracks the pin. When it is 0, only armed pins track, so an unarmed pin that rose is reported once it is armed for a rising edge.
- R8: A write to address 4 clears each status bit whose data bit is 1. The other status bits keep their value.
- R9: When a set event and a clear of the same bit fall in one cycle, the bit stays set.
- R10: The interrupt request is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | NPIN | Synchronized pin levels |
| sys_tick_i | input | 1 | Fast clock-enable for the divider |
| slow_tick_i | input | 1 | Slow clock-enable for the divider |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 2*NPIN | Register write data |
| sts_o | output | NPIN | Pending status bits |
| irq_o | output | 1 | OR of all status bits |

## Verification
The bench builds the block with its defaults: NPIN = 16 and a 4-bit period select. With these values every register field sits where the requirements place it. The shortest periods (N = 0, 2 and 4) keep the acceptance windows to a few dozen cycles. The bench holds the system tick high, so one sample period is exactly 2^N cycles. This makes glitch, short-pulse and long-hold cases straightforward to sweep. The bench drives the slow tick by hand, which lets it place each sampling point and confirm that the source select is honoured.

// File: rtl/pid_pkg.sv
`timescale 1ns/1ps
package pid_pkg;
    typedef enum logic [2:0] {
        A_EN    = 3'd0,
        A_TYPE  = 3'd1,
        A_DBEN  = 3'd2,
        A_DBCTL = 3'd3,
        A_CLR   = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/pid_divider.sv
`timescale 1ns/1ps
module pid_divider #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             src_tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             smp_o
);
    localparam int CW = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          smp;
    } div_t;

    div_t s_d, s_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim     = ~({CW{1'b1}} << sel_i);
        s_d     = s_q;
        s_d.smp = 1'b0;
        if (restart_i) begin
            s_d.cnt = '0;
        end else if (src_tick_i) begin
            if (s_q.cnt >= lim) begin
                s_d.cnt = '0;
                s_d.smp = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign smp_o = s_q.smp;
endmodule

// File: rtl/pid_debounce.sv
`timescale 1ns/1ps
module pid_debounce #(
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_i,
    input  logic [NPIN-1:0] pins_i,
    input  logic [NPIN-1:0] dben_i,
    output logic [NPIN-1:0] filt_o,
    output logic [NPIN-1:0] stb_o
);
    typedef struct packed {
        logic [NPIN-1:0] last;
        logic [NPIN-1:0] stb;
    } db_t;

    db_t s_d, s_q;
    logic [NPIN-1:0] agree;

    always_comb begin
        s_d   = s_q;
        agree = ~(pins_i ^ s_q.last);
        if (smp_i) begin
            s_d.last = pins_i;
            s_d.stb  = (agree & pins_i) | (~agree & s_q.stb);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_sel
        assign filt_o[g] = dben_i[g] ? s_q.stb[g] : pins_i[g];
    end

    assign stb_o = s_q.stb;
endmodule

// File: rtl/pid_detect.sv
`timescale 1ns/1ps
module pid_detect #(
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] filt_i,
    input  logic [NPIN-1:0] en_lo_i,
    input  logic [NPIN-1:0] en_hi_i,
    input  logic [NPIN-1:0] lvl_i,
    input  logic            keep_i,
    output logic [NPIN-1:0] evt_o
);
    typedef struct packed {
        logic [NPIN-1:0] prev;
    } det_t;

    det_t s_d, s_q;
    logic [NPIN-1:0] act, rise, fall, edge_evt, lvl_evt;

    always_comb begin
        act      = keep_i ? {NPIN{1'b1}} : (en_lo_i | en_hi_i);
        rise     = filt_i & ~s_q.prev;
        fall     = ~filt_i & s_q.prev;
        edge_evt = act & ((en_hi_i & rise) | (en_lo_i & fall));
        lvl_evt  = (en_hi_i & filt_i) | (en_lo_i & ~filt_i);
        evt_o    = (lvl_i & lvl_evt) | (~lvl_i & edge_evt);
        s_d.prev = (act & filt_i) | (~act & s_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pin_irq_detect.sv
`timescale 1ns/1ps
module pin_irq_detect
    import pid_pkg::*;
#(
    parameter int NPIN  = 16,
    parameter int SEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pins_i,
    input  logic              sys_tick_i,
    input  logic              slow_tick_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [2*NPIN-1:0] wr_data_i,
    output logic [NPIN-1:0]   sts_o,
    output logic              irq_o
);
    localparam int DW      = 2 * NPIN;
    localparam int SRC_BIT = SEL_W;
    localparam int ON_BIT  = SEL_W + 1;

    typedef struct packed {
        logic [DW-1:0]    en;
        logic [NPIN-1:0]  lvl;
        logic [NPIN-1:0]  dben;
        logic [SEL_W-1:0] nsel;
        logic             slow;
        logic             keep;
        logic [NPIN-1:0]  sts;
    } regs_t;

    regs_t r_d, r_q;
    logic            restart, src_tick, smp;
    logic [NPIN-1:0] filt, stb, evt, clr;

    assign src_tick = r_q.slow ? slow_tick_i : sys_tick_i;

    pid_divider #(.SEL_W(SEL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .restart_i(restart),
        .src_tick_i(src_tick), .sel_i(r_q.nsel), .smp_o(smp)
    );

    pid_debounce #(.NPIN(NPIN)) u_db (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .pins_i(pins_i),
        .dben_i(r_q.dben), .filt_o(filt), .stb_o(stb)
    );

    pid_detect #(.NPIN(NPIN)) u_det (
        .clk(clk), .rst_n(rst_n), .filt_i(filt),
        .en_lo_i(r_q.en[NPIN-1:0]), .en_hi_i(r_q.en[DW-1:NPIN]),
        .lvl_i(r_q.lvl), .keep_i(r_q.keep), .evt_o(evt)
    );

    always_comb begin
        r_d     = r_q;
        restart = 1'b0;
        clr     = '0;
        if (wr_en_i) begin
            case (reg_addr_e'(wr_addr_i))
                A_EN:    r_d.en   = wr_data_i;
                A_TYPE:  r_d.lvl  = wr_data_i[NPIN-1:0];
                A_DBEN:  r_d.dben = wr_data_i[NPIN-1:0];
                A_DBCTL: begin
                    r_d.nsel = wr_data_i[SEL_W-1:0];
                    r_d.slow = wr_data_i[SRC_BIT];
                    r_d.keep = wr_data_i[ON_BIT];
                    restart  = 1'b1;
                end
                A_CLR:   clr = wr_data_i[NPIN-1:0];
                default: ;
            endcase
        end
        // a set event outranks a clear in the same cycle
        r_d.sts = (r_q.sts & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sts_o = r_q.sts;
    assign irq_o = |r_q.sts;
endmodule

// File: rtl/pid_checker.sv
`timescale 1ns/1ps
module pid_checker #(
    parameter int NPIN  = 16,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [NPIN-1:0]  wr_lo,
    input logic [NPIN-1:0]  sts,
    input logic [NPIN-1:0]  en_lo,
    input logic [NPIN-1:0]  en_hi,
    input logic [NPIN-1:0]  lvl,
    input logic [NPIN-1:0]  filt,
    input logic [NPIN-1:0]  stb,
    input logic             smp,
    input logic [SEL_W-1:0] nsel
);
    logic [NPIN-1:0] clr_m;
    assign clr_m = (wr_en && wr_addr == 3'd4) ? wr_lo : '0;

    // R8: bits not written with one stay set
    a_r8_w1c_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(sts) & ~$past(clr_m)) & ~sts) == '0));

    // R2: a newly set bit belongs to an armed pin
    a_r2_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((sts & ~$past(sts)) & ~$past(en_lo | en_hi)) == '0));

    // R3 and R9: an active armed level leaves the bit set
    a_r9_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(lvl & en_hi & filt) & ~sts) == '0));

    // R4: with N above zero sampling points are never adjacent
    a_r4_sample_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && nsel != '0) |=> !smp);

    // R6: the filtered level only moves after a sampling point
    a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !smp |=> $stable(stb));
endmodule

bind pin_irq_detect pid_checker #(.NPIN(NPIN), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_lo(wr_data_i[NPIN-1:0]), .sts(r_q.sts),
    .en_lo(r_q.en[NPIN-1:0]), .en_hi(r_q.en[2*NPIN-1:NPIN]),
    .lvl(r_q.lvl), .filt(filt), .stb(stb), .smp(smp), .nsel(r_q.nsel)
);

// File: tb/tb_pin_irq_detect.sv
`timescale 1ns/1ps
module tb_pin_irq_detect;
    localparam int NPIN = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPIN-1:0]   pins = '0;
    logic              sys_tick = 1'b1;
    logic              slow_tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [2*NPIN-1:0] wr_data = '0;
    logic [NPIN-1:0]   sts_o;
    logic              irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [NPIN-1:0] sts;
        string           rid;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    pin_irq_detect #(.NPIN(NPIN), .SEL_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .sys_tick_i(sys_tick),
        .slow_tick_i(slow_tick), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .sts_o(sts_o), .irq_o(irq_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic expect_sts(input logic [NPIN-1:0] s, input string rid);
        exp_t e;
        e.sts = s;
        e.rid = rid;
        sb.push_back(e);
    endtask

    // monitor: compares queued expectations half a cycle after the edge
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (sts_o !== e.sts) begin
                errors++;
                $display("FAIL %s status actual=%h expected=%h", e.rid, sts_o, e.sts);
            end
            checks++;
            if (irq_o !== (|e.sts)) begin
                errors++;
                $display("FAIL R10 irq actual=%b expected=%b", irq_o, |e.sts);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        expect_sts('0, "R1");

        // edge detection, keep-alive on
        wr(3'd3, 32'h20);
        wr(3'd0, 32'h0003_0005);
        pins[2:0] = 3'b111;
        tick();
        expect_sts(16'h0003, "R2");
        wr(3'd4, 32'h3);
        expect_sts(16'h0000, "R8");
        pins[2:0] = 3'b000;
        tick();
        expect_sts(16'h0005, "R2");
        wr(3'd4, 32'h4);
        expect_sts(16'h0001, "R8");
        wr(3'd4, 32'h1);
        expect_sts(16'h0000, "R8");

        // level mode
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h8);
        wr(3'd0, 32'h0008_0000);
        pins[3] = 1'b1;
        tick();
        expect_sts(16'h0008, "R3");
        wr(3'd4, 32'h8);
        expect_sts(16'h0008, "R9");
        tick();
        expect_sts(16'h0008, "R3");
        pins[3] = 1'b0;
        tick();
        wr(3'd4, 32'h8);
        expect_sts(16'h0000, "R3");
        wr(3'd0, 32'h8);
        tick();
        expect_sts(16'h0008, "R3");
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h8);
        expect_sts(16'h0000, "R8");
        wr(3'd1, 32'h0);

        // keep-alive switch
        wr(3'd3, 32'h0);
        pins[4] = 1'b1;
        ticks(2);
        expect_sts(16'h0000, "R7");
        wr(3'd0, 32'h0010_0000);
        tick();
        expect_sts(16'h0010, "R7");
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h10);
        expect_sts(16'h0000, "R8");
        wr(3'd3, 32'h20);
        pins[4] = 1'b0;
        ticks(2);
        pins[4] = 1'b1;
        ticks(2);
        wr(3'd0, 32'h0010_0000);
        tick();
        expect_sts(16'h0000, "R7");
        wr(3'd0, 32'h0);

        // debounce, N = 2, system tick
        wr(3'd3, 32'h22);
        wr(3'd2, 32'h20);
        wr(3'd0, 32'h0020_0000);
        pins[5] = 1'b1;
        tick();
        pins[5] = 1'b0;
        ticks(8);
        expect_sts(16'h0000, "R6");
        pins[5] = 1'b1;
        ticks(3);
        expect_sts(16'h0000, "R6");
        ticks(9);
        expect_sts(16'h0020, "R6");
        wr(3'd4, 32'h20);
        expect_sts(16'h0000, "R8");

        // period of 16 ticks, N = 4
        wr(3'd3, 32'h24);
        wr(3'd0, 32'h0020_0020);
        pins[5] = 1'b0;
        ticks(10);
        pins[5] = 1'b1;
        ticks(40);
        expect_sts(16'h0000, "R4");
        pins[5] = 1'b0;
        ticks(40);
        expect_sts(16'h0020, "R4");
        wr(3'd4, 32'h20);
        expect_sts(16'h0000, "R8");

        // slow tick source, N = 0
        wr(3'd3, 32'h30);
        pins[5] = 1'b1;
        ticks(20);
        expect_sts(16'h0000, "R5");
        slow_tick = 1'b1;
        tick();
        slow_tick = 1'b0;
        ticks(2);
        slow_tick = 1'b1;
        tick();
        slow_tick = 1'b0;
        ticks(3);
        expect_sts(16'h0020, "R5");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule